// File: doc/BRIEF.md
# Two-Wire Bus Transaction Monitor

This block watches the clock and data lines of an I2C bus without ever driving them. It turns the line activity into a stream of decoded events. Both lines are resynchronised into the local clock domain. Changes are then found by comparing each sample with the one before it. A three-state sequencer (idle, address, data) decides which bus conditions count at each point in a transfer.

Each event is a one-cycle strobe with three fields: a 3-bit code, a byte and an acknowledge bit. The events are start, repeated start and stop markers, plus one event per completed 9-bit frame. A frame event reports the received byte and whether the receiver acknowledged it. A frame is classified as an address or data frame, in the read or write direction.

Top module: `i2cmon`

## Requirements
- R1: A synchronous active-high reset returns the monitor to idle with every counter and flag cleared and `evValid` low. Line samples taken while the synchroniser fills, and the first comparison after it, never raise an event.
- R2: In idle, a falling data line while the clock line is high raises a start event with code 0.
- R3: Bits are taken on each rising edge of the clock line, most significant first. A frame is 9 bits: 8 byte bits, then the acknowledge bit (0 = ACK, 1 = NACK), which is reported on `evAck`.
- R4: The first frame after any start is an address frame. Bit 0 of the received byte is the direction (1 = read, 0 = write). It gives code 4 for a read and code 3 for a write. `evByte` carries the byte with bit 0 cleared.
- R5: After the address frame, any number of data frames follow. Each is reported with its full byte: code 6 if the latched direction is read, code 5 if it is write.
- R6: A start condition seen in the data state raises a repeated-start event (code 1) and re-enters the address state. Any partially received frame is discarded.
- R7: A stop condition (data line rising while the clock line is high) in the data state raises a stop event (code 2). It returns to idle and clears the direction and the repeated-start flag. The next start is therefore a plain start (code 0).
- R8: In the address state, start and stop conditions are ignored and the frame keeps collecting bits.
- R9: In idle, clock-line rising edges and stop conditions raise no event.
- R10: Start, repeated-start and stop events carry `evByte` = 0 and `evAck` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| scl | input | 1 | Bus clock line (asynchronous) |
| sda | input | 1 | Bus data line (asynchronous) |
| evValid | output | 1 | One-cycle event strobe |
| evCode | output | 3 | Event code (0 start, 1 repeated start, 2 stop, 3 address write, 4 address read, 5 data write, 6 data read) |
| evByte | output | 8 | Frame byte (address with bit 0 cleared), 0 for markers |
| evAck | output | 1 | Acknowledge bit of the frame (1 = NACK), 0 for markers |

## Verification
The assertions rest on the bus line levels being idle high at reset release. They also rely on each line level being held for several local clocks, so that every bus edge reaches the comparator as a clean single-cycle difference. The bench drives both lines from the falling edge of the local clock and holds every level for four clocks. It changes the data line while the clock line is low, except where a start or stop condition is intended. Deliberate conditions inside an address frame still keep each level stable for the full hold time.

// File: rtl/i2cmon_pkg.sv
package i2cmon_pkg;

  typedef enum logic [2:0] {
    EV_START   = 3'd0,
    EV_RSTART  = 3'd1,
    EV_STOP    = 3'd2,
    EV_ADDR_WR = 3'd3,
    EV_ADDR_RD = 3'd4,
    EV_DATA_WR = 3'd5,
    EV_DATA_RD = 3'd6
  } evCode_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2
  } monState_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic    clrFrame;
    logic    shiftBit;
    logic    emit;
    logic    frameEv;
    logic    addrFrame;
    evCode_t code;
  } ctlStrobe_t;

endpackage

// File: rtl/i2cmon_datapath.sv
module i2cmon_datapath
  import i2cmon_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  ctlStrobe_t        ctl,
  output logic              startCond,
  output logic              stopCond,
  output logic              bitEdge,
  output logic              lastBit,
  output logic              dirBit,
  output logic              evValid,
  output logic [2:0]        evCode,
  output logic [DATA_W-1:0] evByte,
  output logic              evAck
);

  localparam int FRAME_W = DATA_W + 1;
  localparam int CNT_W   = $clog2(FRAME_W + 1);
  localparam int FILL_N  = SYNC_STAGES + 1;
  localparam int FILL_W  = $clog2(FILL_N + 1);

  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic                   sclNow, sdaNow, sclPrev, sdaPrev;
  logic [FILL_W-1:0]      fillCnt;
  logic                   primed;
  logic [CNT_W-1:0]       bitCnt;
  logic [DATA_W-1:0]      shiftReg;

  // resynchronisers, reset to the idle-high bus level
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk) begin
        if (rst) begin
          sclPipe <= '1;
          sdaPipe <= '1;
        end else begin
          sclPipe <= sclIn;
          sdaPipe <= sdaIn;
        end
      end
    end else begin : g_syncN
      always_ff @(posedge clk) begin
        if (rst) begin
          sclPipe <= '1;
          sdaPipe <= '1;
        end else begin
          sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
          sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
        end
      end
    end
  endgenerate

  assign sclNow = sclPipe[SYNC_STAGES-1];
  assign sdaNow = sdaPipe[SYNC_STAGES-1];

  // previous-sample registers and the fill counter that arms the comparator
  always_ff @(posedge clk) begin
    if (rst) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
      fillCnt <= '0;
    end else begin
      sclPrev <= sclNow;
      sdaPrev <= sdaNow;
      if (!primed) fillCnt <= fillCnt + 1'b1;
    end
  end

  assign primed    = (fillCnt == FILL_W'(FILL_N));
  assign startCond = primed & sclNow & sdaPrev & ~sdaNow;
  assign stopCond  = primed & sclNow & ~sdaPrev & sdaNow;
  assign bitEdge   = primed & ~sclPrev & sclNow;

  // frame assembly
  always_ff @(posedge clk) begin
    if (rst || ctl.clrFrame) begin
      bitCnt   <= '0;
      shiftReg <= '0;
    end else if (ctl.shiftBit) begin
      bitCnt   <= bitCnt + 1'b1;
      shiftReg <= {shiftReg[DATA_W-2:0], sdaNow};
    end
  end

  assign lastBit = (bitCnt == CNT_W'(FRAME_W - 1));
  assign dirBit  = shiftReg[0];

  // event output register
  always_ff @(posedge clk) begin
    if (rst) begin
      evValid <= 1'b0;
      evCode  <= '0;
      evByte  <= '0;
      evAck   <= 1'b0;
    end else begin
      evValid <= ctl.emit;
      evCode  <= ctl.emit ? ctl.code : 3'd0;
      if (ctl.emit && ctl.frameEv) begin
        evByte <= ctl.addrFrame ? {shiftReg[DATA_W-1:1], 1'b0} : shiftReg;
        evAck  <= sdaNow;
      end else begin
        evByte <= '0;
        evAck  <= 1'b0;
      end
    end
  end

  a_r3_count_bound: assert property (@(posedge clk) disable iff (rst)
    bitCnt <= CNT_W'(FRAME_W - 1));

  a_r1_quiet_unprimed: assert property (@(posedge clk) disable iff (rst)
    !primed |-> !ctl.emit);

  a_r10_marker_fields: assert property (@(posedge clk) disable iff (rst)
    (evValid && evCode <= 3'd2) |-> (evByte == '0 && !evAck));

  a_r3_shift_only_on_edge: assert property (@(posedge clk) disable iff (rst)
    ctl.shiftBit |-> bitEdge);

endmodule

// File: rtl/i2cmon_control.sv
module i2cmon_control
  import i2cmon_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       startCond,
  input  logic       stopCond,
  input  logic       bitEdge,
  input  logic       lastBit,
  input  logic       dirBit,
  input  logic       sdaNowUnused,
  output ctlStrobe_t ctl
);

  monState_t state, stateNext;
  logic      repFlag;
  logic      dirReg, dirValid;
  logic      unusedIn;

  assign unusedIn = sdaNowUnused;

  always_comb begin
    ctl       = '0;
    stateNext = state;
    case (state)
      ST_IDLE: begin
        if (startCond) begin
          ctl.emit     = 1'b1;
          ctl.code     = repFlag ? EV_RSTART : EV_START;
          ctl.clrFrame = 1'b1;
          stateNext    = ST_ADDR;
        end
      end
      ST_ADDR: begin
        if (bitEdge) begin
          if (lastBit) begin
            ctl.emit      = 1'b1;
            ctl.frameEv   = 1'b1;
            ctl.addrFrame = 1'b1;
            ctl.code      = dirBit ? EV_ADDR_RD : EV_ADDR_WR;
            ctl.clrFrame  = 1'b1;
            stateNext     = ST_DATA;
          end else begin
            ctl.shiftBit = 1'b1;
          end
        end
      end
      ST_DATA: begin
        if (bitEdge) begin
          if (lastBit) begin
            ctl.emit     = 1'b1;
            ctl.frameEv  = 1'b1;
            ctl.code     = dirReg ? EV_DATA_RD : EV_DATA_WR;
            ctl.clrFrame = 1'b1;
          end else begin
            ctl.shiftBit = 1'b1;
          end
        end else if (startCond) begin
          ctl.emit     = 1'b1;
          ctl.code     = EV_RSTART;
          ctl.clrFrame = 1'b1;
          stateNext    = ST_ADDR;
        end else if (stopCond) begin
          ctl.emit     = 1'b1;
          ctl.code     = EV_STOP;
          ctl.clrFrame = 1'b1;
          stateNext    = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      repFlag  <= 1'b0;
      dirReg   <= 1'b0;
      dirValid <= 1'b0;
    end else begin
      state <= stateNext;
      if (ctl.emit && (ctl.code == EV_START || ctl.code == EV_RSTART)) begin
        repFlag  <= 1'b1;
        dirValid <= 1'b0;
      end else if (ctl.emit && ctl.code == EV_STOP) begin
        repFlag  <= 1'b0;
        dirValid <= 1'b0;
      end else if (ctl.emit && ctl.addrFrame) begin
        dirReg   <= dirBit;
        dirValid <= 1'b1;
      end
    end
  end

  a_r6_rstart_from_data: assert property (@(posedge clk) disable iff (rst)
    (ctl.emit && ctl.code == EV_RSTART) |-> state == ST_DATA);

  a_r7_stop_to_idle: assert property (@(posedge clk) disable iff (rst)
    (ctl.emit && ctl.code == EV_STOP) |=> (state == ST_IDLE && !repFlag && !dirValid));

  a_r8_addr_no_markers: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ADDR && ctl.emit) |-> ctl.frameEv);

  a_r5_data_has_dir: assert property (@(posedge clk) disable iff (rst)
    (ctl.emit && (ctl.code == EV_DATA_RD || ctl.code == EV_DATA_WR)) |-> dirValid);

  a_r9_idle_only_start: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && ctl.emit) |-> ctl.code == EV_START);

endmodule

// File: rtl/i2cmon.sv
module i2cmon
  import i2cmon_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl,
  input  logic              sda,
  output logic              evValid,
  output logic [2:0]        evCode,
  output logic [DATA_W-1:0] evByte,
  output logic              evAck
);

  ctlStrobe_t ctl;
  logic startCond, stopCond, bitEdge, lastBit, dirBit;

  i2cmon_datapath #(.SYNC_STAGES(SYNC_STAGES), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst(rst), .sclIn(scl), .sdaIn(sda), .ctl(ctl),
    .startCond(startCond), .stopCond(stopCond), .bitEdge(bitEdge),
    .lastBit(lastBit), .dirBit(dirBit),
    .evValid(evValid), .evCode(evCode), .evByte(evByte), .evAck(evAck)
  );

  i2cmon_control u_ctl (
    .clk(clk), .rst(rst), .startCond(startCond), .stopCond(stopCond),
    .bitEdge(bitEdge), .lastBit(lastBit), .dirBit(dirBit),
    .sdaNowUnused(1'b0), .ctl(ctl)
  );

endmodule

// File: tb/i2cmon_tb.sv
module i2cmon_tb;

  localparam int HOLD = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl = 1'b1;
  logic       sda = 1'b1;
  logic       evValid;
  logic [2:0] evCode;
  logic [7:0] evByte;
  logic       evAck;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  logic [11:0] obs [64];
  int          nObs = 0;
  logic [11:0] expq [32];
  int          nExp = 0;
  int          obsBase = 0;

  always #5 clk = ~clk;

  i2cmon u_dut (
    .clk(clk), .rst(rst), .scl(scl), .sda(sda),
    .evValid(evValid), .evCode(evCode), .evByte(evByte), .evAck(evAck)
  );

  // event capture away from the active edge
  always @(negedge clk) begin
    if (!rst && evValid) begin
      if (nObs < 64) obs[nObs] = {evCode, evByte, evAck};
      nObs++;
    end
  end

  task automatic setLines(input logic s, input logic d);
    @(negedge clk);
    scl = s;
    sda = d;
    repeat (HOLD) @(negedge clk);
  endtask

  task automatic busStart();
    setLines(1, 1);
    setLines(1, 0);
    setLines(0, 0);
  endtask

  task automatic busRestart();
    setLines(0, 1);
    setLines(1, 1);
    setLines(1, 0);
    setLines(0, 0);
  endtask

  task automatic busStop();
    setLines(0, 0);
    setLines(1, 0);
    setLines(1, 1);
  endtask

  task automatic busBit(input logic b);
    setLines(0, b);
    setLines(1, b);
    setLines(0, b);
  endtask

  task automatic sendFrame(input logic [7:0] b, input logic ack);
    for (int i = 7; i >= 0; i--) busBit(b[i]);
    busBit(ack);
  endtask

  task automatic beginScenario();
    obsBase = nObs;
    nExp    = 0;
  endtask

  task automatic expectEv(input logic [2:0] c, input logic [7:0] b, input logic a);
    expq[nExp] = {c, b, a};
    nExp++;
  endtask

  task automatic checkScenario(input string req);
    repeat (10) @(negedge clk);
    checks++;
    if (nObs - obsBase != nExp) begin
      errors++;
      $display("FAIL %s: event count actual=%0d expected=%0d", req, nObs - obsBase, nExp);
    end
    for (int i = 0; i < nExp; i++) begin
      if (obsBase + i < nObs && obsBase + i < 64) begin
        checks++;
        if (obs[obsBase + i] !== expq[i]) begin
          errors++;
          $display("FAIL %s: event %0d actual code=%0d byte=%h ack=%b expected code=%0d byte=%h ack=%b",
                   req, i, obs[obsBase+i][11:9], obs[obsBase+i][8:1], obs[obsBase+i][0],
                   expq[i][11:9], expq[i][8:1], expq[i][0]);
        end
      end
    end
  endtask

  // R1: reset state and quiet start-up
  task automatic testReset();
    checks++;
    if (evValid !== 1'b0) begin
      errors++;
      $display("FAIL R1: evValid during reset actual=%b expected=0", evValid);
    end
    @(negedge clk);
    rst = 1'b0;
    beginScenario();
    repeat (12) @(negedge clk);
    checkScenario("R1");
  endtask

  // R9: bit edges and stop in idle are ignored
  task automatic testIdleIgnore();
    beginScenario();
    busBit(1);
    busBit(0);
    busStop();
    checkScenario("R9");
  endtask

  // R2 R3 R4 R5 R7 R10: write transfer
  task automatic testWrite();
    beginScenario();
    busStart();     expectEv(3'd0, 8'h00, 1'b0);
    sendFrame(8'hA4, 1'b0); expectEv(3'd3, 8'hA4, 1'b0);
    sendFrame(8'h3C, 1'b0); expectEv(3'd5, 8'h3C, 1'b0);
    sendFrame(8'hFF, 1'b1); expectEv(3'd5, 8'hFF, 1'b1);
    busStop();      expectEv(3'd2, 8'h00, 1'b0);
    checkScenario("R5_write");
  endtask

  // R6 R4 R5 R7: combined transfer with repeated start, plain start after stop
  task automatic testRead();
    beginScenario();
    busStart();     expectEv(3'd0, 8'h00, 1'b0);
    sendFrame(8'h50, 1'b0); expectEv(3'd3, 8'h50, 1'b0);
    sendFrame(8'h01, 1'b0); expectEv(3'd5, 8'h01, 1'b0);
    busRestart();   expectEv(3'd1, 8'h00, 1'b0);
    sendFrame(8'h51, 1'b0); expectEv(3'd4, 8'h50, 1'b0);
    sendFrame(8'h9A, 1'b1); expectEv(3'd6, 8'h9A, 1'b1);
    busStop();      expectEv(3'd2, 8'h00, 1'b0);
    checkScenario("R6_read");
  endtask

  // R6: partial data frame discarded by a repeated start
  task automatic testPartial();
    beginScenario();
    busStart();     expectEv(3'd0, 8'h00, 1'b0);
    sendFrame(8'hA0, 1'b0); expectEv(3'd3, 8'hA0, 1'b0);
    busBit(1); busBit(1); busBit(0);
    busRestart();   expectEv(3'd1, 8'h00, 1'b0);
    sendFrame(8'hA1, 1'b1); expectEv(3'd4, 8'hA0, 1'b1);
    sendFrame(8'h5A, 1'b0); expectEv(3'd6, 8'h5A, 1'b0);
    busStop();      expectEv(3'd2, 8'h00, 1'b0);
    checkScenario("R6_partial");
  endtask

  // R8: stop and start inside the address frame are ignored
  task automatic testAddrIgnore();
    logic [7:0] rest;
    rest = 8'h55;
    beginScenario();
    busStart();     expectEv(3'd0, 8'h00, 1'b0);
    setLines(0, 0);
    setLines(1, 0);   // first bit = 0
    setLines(1, 1);   // stop condition, ignored
    setLines(1, 0);   // start condition, ignored
    setLines(0, 0);
    for (int i = 6; i >= 0; i--) busBit(rest[i]);
    busBit(1'b0);   expectEv(3'd4, 8'h54, 1'b0);
    busStop();      expectEv(3'd2, 8'h00, 1'b0);
    checkScenario("R8");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    testIdleIgnore();
    testWrite();
    testRead();
    testPartial();
    testAddrIgnore();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=expired expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule